// File: doc/BRIEF.md
# Output Column Cell Scheduler

This block decides, once per time slot, which of the N buffers in one output column of a buffered crossbar sends its head cell to the output. Each buffer reports its current occupancy. The block combines these counts with a small amount of stored state, a pointer and a pseudo-random register, and produces a grant in two forms, a one-hot vector and a binary index, plus a valid flag.

A static mode input selects the policy. Largest-occupancy-first grants the fullest buffer. Exhaustive rotation keeps serving one buffer until it drains and then moves to the next occupied buffer in circular order. The random policy starts a circular search at a pseudo-random position. In every mode the block is work-conserving: the grant is valid in every slot in which any buffer in the column holds a cell.

The grant is combinational from the occupancy inputs and the stored state. The state changes on the rising clock edge that ends the slot. The environment reads the granted buffer and updates the occupancy counts.

Top module: `col_sched`

## Requirements
- R1: In largest-occupancy mode, the grant goes to the buffer with the highest occupancy. When several buffers share that maximum, the lowest index wins.
- R2: In rotation mode, a buffer granted in one slot is granted again in the next slot if it is still non-empty and the mode is still rotation.
- R3: In rotation mode, the pointer resets to 0. If the buffer at the pointer is non-empty, it is granted. Otherwise the grant goes to the first non-empty buffer after the pointer, wrapping past N-1 to 0. On every rotation-mode grant, the pointer loads the granted index.
- R4: In every mode, the grant is valid whenever at least one occupancy count is non-zero.
- R5: In random mode, a 16-bit register is set to 0xACE1 by reset. After reset it advances on every clock edge as q <= {q[14:0], q[15]^q[13]^q[12]^q[10]}. The search start is q mod N. The grant goes to the first non-empty buffer at or after the start, wrapping around.
- R6: Bit k of the one-hot grant is set only when the grant is valid and the index equals k. No other bit is set.
- R7: When all counts are zero, the grant is not valid, the one-hot grant is all zeros, and the index is 0. The rotation pointer keeps its value, so the next rotation search starts from where it left off.
- R8: Mode code 0 selects largest occupancy, 1 selects rotation, and 2 selects random. Code 3 behaves exactly like code 0.
- R9: Outside rotation mode, grants do not move the rotation pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Policy select (0 largest, 1 rotation, 2 random, 3 largest) |
| occ_i | input | N_PORTS*OCC_W | Occupancy counts; buffer k in bits [k*OCC_W +: OCC_W] |
| gnt_oh_o | output | N_PORTS | One-hot grant |
| gnt_idx_o | output | $clog2(N_PORTS) | Granted buffer index |
| gnt_vld_o | output | 1 | Grant valid |

## Verification
The rotation pointer is the hardest state to reach from the ports. To stay on one buffer for several slots, that buffer must stay non-empty while its neighbours are also busy. Independent random counts in each slot almost never hold that shape. The bench therefore models a real column: each slot, the granted buffer loses one cell and random arrivals add cells, so buffers drain gradually and rotation runs last many slots. Directed sequences then drain the column to empty and refill it on both sides of the pointer, which shows that the pointer held through the idle slot and that the search wraps.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    MODE_LQF  = 2'd0,
    MODE_RR   = 2'd1,
    MODE_RAND = 2'd2,
    MODE_ALT  = 2'd3
  } sched_mode_e;

  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
endpackage

// File: rtl/lfsr_gen.sv
module lfsr_gen
  import sched_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] q;
  logic              fb;

  assign fb = ^(q & LFSR_TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= LFSR_SEED;
    else         q <= {q[LFSR_W-2:0], fb};
  end

  assign state_o = q;

  // a maximal sequence never reaches the all-zero lock state
  AST_LFSR_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q != '0); // R5
endmodule

// File: rtl/lqf_pick.sv
module lqf_pick #(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned OCC_W   = 7,
  localparam int unsigned IDX_W  = $clog2(N_PORTS)
) (
  input  logic [N_PORTS*OCC_W-1:0] occ_i,
  output logic                     vld_o,
  output logic [IDX_W-1:0]         idx_o
);
  logic [OCC_W-1:0] best;

  // strict compare keeps the lowest index on ties
  always_comb begin
    best  = '0;
    idx_o = '0;
    for (int unsigned i = 0; i < N_PORTS; i++) begin
      if (occ_i[i*OCC_W +: OCC_W] > best) begin
        best  = occ_i[i*OCC_W +: OCC_W];
        idx_o = IDX_W'(i);
      end
    end
  end

  assign vld_o = (best != '0);
endmodule

// File: rtl/rot_pick.sv
module rot_pick #(
  parameter int unsigned N_PORTS = 8,
  localparam int unsigned IDX_W  = $clog2(N_PORTS)
) (
  input  logic [N_PORTS-1:0] req_i,
  input  logic [IDX_W-1:0]   start_i,
  output logic               vld_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int unsigned k = 0; k < N_PORTS; k++) begin
      int unsigned j;
      j = (int'(start_i) + k) % N_PORTS;
      if (!vld_o && req_i[j]) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/col_sched.sv
module col_sched
  import sched_pkg::*;
#(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned OCC_W   = 7,
  localparam int unsigned IDX_W  = $clog2(N_PORTS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               mode_i,
  input  logic [N_PORTS*OCC_W-1:0] occ_i,
  output logic [N_PORTS-1:0]       gnt_oh_o,
  output logic [IDX_W-1:0]         gnt_idx_o,
  output logic                     gnt_vld_o
);
  logic [OCC_W-1:0]  occ_a [N_PORTS];
  logic [N_PORTS-1:0] nonempty;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_lane
    assign occ_a[g]    = occ_i[g*OCC_W +: OCC_W];
    assign nonempty[g] = (occ_a[g] != '0);
  end

  logic             lqf_vld, rr_vld, rnd_vld;
  logic [IDX_W-1:0] lqf_idx, rr_idx, rnd_idx;
  logic [IDX_W-1:0] rr_ptr_q, rnd_start;
  logic [LFSR_W-1:0] lfsr_q;

  lqf_pick #(.N_PORTS(N_PORTS), .OCC_W(OCC_W)) u_lqf (
    .occ_i (occ_i),
    .vld_o (lqf_vld),
    .idx_o (lqf_idx)
  );

  rot_pick #(.N_PORTS(N_PORTS)) u_rr (
    .req_i   (nonempty),
    .start_i (rr_ptr_q),
    .vld_o   (rr_vld),
    .idx_o   (rr_idx)
  );

  lfsr_gen u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (lfsr_q)
  );

  assign rnd_start = IDX_W'(lfsr_q % LFSR_W'(N_PORTS));

  rot_pick #(.N_PORTS(N_PORTS)) u_rnd (
    .req_i   (nonempty),
    .start_i (rnd_start),
    .vld_o   (rnd_vld),
    .idx_o   (rnd_idx)
  );

  always_comb begin
    unique case (sched_mode_e'(mode_i))
      MODE_RR: begin
        gnt_vld_o = rr_vld;
        gnt_idx_o = rr_idx;
      end
      MODE_RAND: begin
        gnt_vld_o = rnd_vld;
        gnt_idx_o = rnd_idx;
      end
      default: begin
        gnt_vld_o = lqf_vld;
        gnt_idx_o = lqf_idx;
      end
    endcase
  end

  for (genvar g = 0; g < N_PORTS; g++) begin : g_oh
    assign gnt_oh_o[g] = gnt_vld_o && (gnt_idx_o == IDX_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      rr_ptr_q <= '0;
    else if (gnt_vld_o && mode_i == MODE_RR)          rr_ptr_q <= gnt_idx_o;
  end

  AST_WORK_CONSERVING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|nonempty) |-> gnt_vld_o); // R4
  AST_GNT_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_vld_o |-> occ_a[gnt_idx_o] != '0); // R4
  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_oh_o) && ((|gnt_oh_o) == gnt_vld_o)); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_vld_o |-> gnt_idx_o == '0 && nonempty == '0); // R7
  AST_RR_STICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && mode_i == MODE_RR && $past(mode_i) == MODE_RR &&
    $past(gnt_vld_o) && occ_a[$past(gnt_idx_o)] != '0
    |-> gnt_idx_o == $past(gnt_idx_o)); // R2
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gnt_vld_o || mode_i != MODE_RR) |=> $stable(rr_ptr_q)); // R9

  for (genvar g = 0; g < N_PORTS; g++) begin : g_lqf_chk
    AST_LQF_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_LQF || mode_i == MODE_ALT) && gnt_vld_o |->
      (occ_a[g] <= occ_a[gnt_idx_o]) &&
      (IDX_W'(g) >= gnt_idx_o || occ_a[g] < occ_a[gnt_idx_o])); // R1
  end
endmodule

// File: tb/tb_col_sched.sv
module tb_col_sched;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int W = 7;
  localparam int IW = $clog2(N);
  localparam int OMAX = (1 << W) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    mode_i = 2'd0;
  logic [N*W-1:0] occ_i = '0;
  logic [N-1:0]  gnt_oh_o;
  logic [IW-1:0] gnt_idx_o;
  logic          gnt_vld_o;

  col_sched #(.N_PORTS(N), .OCC_W(W)) dut (
    .clk_i, .rst_ni, .mode_i, .occ_i, .gnt_oh_o, .gnt_idx_o, .gnt_vld_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_vec = 0;
  int n_err = 0;
  int occ_m [N];
  int m_ptr = 0;
  logic [15:0] m_lfsr = 16'hACE1;
  int last_idx = 0;
  int last_vld = 0;

  function automatic logic [15:0] lfsr_step(logic [15:0] q);
    return {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
  endfunction

  function automatic int pick_from(int start);
    for (int k = 0; k < N; k++) begin
      int j = (start + k) % N;
      if (occ_m[j] != 0) return j;
    end
    return -1;
  endfunction

  function automatic int pick_max();
    int best = 0;
    int bi = -1;
    for (int i = 0; i < N; i++)
      if (occ_m[i] > best) begin best = occ_m[i]; bi = i; end
    return bi;
  endfunction

  task automatic fail(string req, string what, int act, int exp);
    n_err++;
    $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
  endtask

  // call at a falling edge; leaves at the next falling edge
  task automatic apply(int mode);
    int e;
    string tag;
    for (int i = 0; i < N; i++) occ_i[i*W +: W] = W'(occ_m[i]);
    mode_i = 2'(mode);
    #2;
    case (mode)
      1: begin e = pick_from(m_ptr); tag = "R3"; end
      2: begin e = pick_from(int'(m_lfsr % 16'(N))); tag = "R5"; end
      3: begin e = pick_max(); tag = "R8"; end
      default: begin e = pick_max(); tag = "R1"; end
    endcase
    n_vec++;
    if (gnt_vld_o !== (e >= 0)) fail(e >= 0 ? "R4" : "R7", "vld", int'(gnt_vld_o), int'(e >= 0));
    if (int'(gnt_idx_o) != (e >= 0 ? e : 0)) fail(tag, "idx", int'(gnt_idx_o), e >= 0 ? e : 0);
    if (gnt_oh_o !== (e >= 0 ? N'(1) << e : N'(0))) fail("R6", "onehot", int'(gnt_oh_o), e >= 0 ? (1 << e) : 0);
    if (mode == 1 && e >= 0) m_ptr = e;
    m_lfsr = lfsr_step(m_lfsr);
    last_idx = e;
    last_vld = (e >= 0);
    @(negedge clk_i);
  endtask

  task automatic clear();
    for (int i = 0; i < N; i++) occ_m[i] = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fail("WDOG", "timeout", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    clear();
    repeat (3) @(negedge clk_i);
    n_vec++;
    if (gnt_vld_o !== 1'b0 || gnt_oh_o !== '0) fail("R7", "reset idle", int'(gnt_vld_o), 0);
    rst_ni = 1'b1;

    // R1 ties and extremes
    clear(); occ_m[0] = 5; occ_m[1] = 9; occ_m[2] = 9; occ_m[3] = 2;
    apply(0);                                   // expect 1 (R1 tie)
    for (int i = 0; i < N; i++) occ_m[i] = 4;
    apply(0);                                   // expect 0
    clear(); occ_m[N-1] = OMAX; occ_m[0] = OMAX - 1;
    apply(0);                                   // expect N-1
    apply(3);                                   // R8 alias
    clear(); occ_m[2] = 9; occ_m[1] = 9;
    apply(3);                                   // R8 tie -> 1

    // R7 empty in every mode
    clear();
    for (int m = 0; m < 4; m++) apply(m);

    // R9: non-rotation grants left pointer at 0; R3 search from 0
    clear(); occ_m[2] = 3; occ_m[5] = 1;
    apply(1);
    if (last_idx != 2) fail("R3", "first search", last_idx, 2);
    occ_m[2]--; apply(1);                       // R2 stick
    if (last_idx != 2) fail("R2", "stick", last_idx, 2);
    occ_m[2]--; apply(1);
    occ_m[2]--; apply(1);                       // lane 2 empty -> 5
    if (last_idx != 5) fail("R3", "advance", last_idx, 5);
    occ_m[5]--; apply(1);                       // all empty
    occ_m[1] = 2; occ_m[6] = 2;
    apply(1);                                   // R7 held ptr 5 -> 6
    if (last_idx != 6) fail("R7", "ptr held", last_idx, 6);
    occ_m[6] = 0; occ_m[0] = 1; apply(1);       // R3 wrap -> 0
    if (last_idx != 0) fail("R3", "wrap", last_idx, 0);
    // R9: largest mode grants elsewhere, pointer stays 0
    occ_m[0] = 0; occ_m[4] = 50; apply(0);
    occ_m[4] = 0; occ_m[3] = 1; occ_m[7] = 1; occ_m[1] = 0;
    apply(1);                                   // from ptr 0 -> 3
    if (last_idx != 3) fail("R9", "ptr untouched", last_idx, 3);

    // R5 directed
    for (int i = 0; i < N; i++) occ_m[i] = 1;
    repeat (8) apply(2);
    clear(); occ_m[6] = 3;
    repeat (4) apply(2);

    // column model: granted lane drains, random arrivals
    clear();
    for (int s = 0; s < 4000; s++) begin
      int md = (s / 400) % 4;
      apply(md);
      if (last_vld != 0) occ_m[last_idx]--;
      for (int i = 0; i < N; i++)
        if ($urandom % 100 < 9 && occ_m[i] < OMAX) occ_m[i]++;
      if ($urandom % 200 == 0) clear();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule